// File: doc/BRIEF.md
# Color Steering Gain Selector

This block picks, pixel by pixel, one of four gain codes to feed a per-pixel gain stage in an image-sensor front end. A programmed steering mode describes how the colour filter array repeats across a line and from line to line. Horizontal and vertical sync inputs, sampled on the pixel clock, mark line and field starts. From them the block keeps a pixel position inside the pattern and a per-line pattern choice, and it reports both the chosen index and the gain code held in that slot.

Seven steering modes cover two-colour line patterns that alternate, repeat or follow the field, three- and four-colour cycles, and a direct mode where the sync levels pick the gain. A separate enable forces the output to the all-ones gain code. Turning the gain into an analog value is left to the stage downstream.

Top module: `color_steer_sel`

## Requirements
- R1: `mode_i` encodings: 0 off, 1 alternating two-colour lines, 2 field-alternating (interlaced) lines, 3 three-colour cycle, 4 four-colour cycle, 5 field-selected lines, 6 shifted-pair lines, 7 direct sync select. One rising clock edge after `mode_i` takes a new value, `idx_o` is 0 with the base line pattern and no pending vertical event. This holds in every mode except 7.
- R2: While `enable_i` is 0, `gain_o` is all ones (63 with the default width), and `idx_o` keeps following the pattern.
- R3: While `enable_i` is 1, `gain_o` equals `gainN_i` where N is `idx_o`. In mode 0, `idx_o` stays 0.
- R4: After reset, `idx_o` is 0, the mode is off and no vertical event is pending.
- R5: `hd_i` and `vd_i` are sampled on rising clock edges, and edges are found between successive samples. A horizontal rising edge changes the pattern state at the second rising clock edge after `hd_i` goes high. The first pixel of the new line then shows.
- R6: Mode 1: a line is either 0,1,0,1… or 2,3,2,3… and always starts at its first entry. A horizontal rising edge with a pending vertical event starts a 0,1 line. Without one, it switches to the other line type.
- R7: Mode 2 follows R6, but a falling edge on `vd_i` also makes a pending vertical event.
- R8: Mode 3 steps 0,1,2,0… once per pixel, and the cycle runs on across horizontal edges. A horizontal rising edge with a pending vertical event restarts it at 0.
- R9: Mode 4 works as R8, stepping 0,1,2,3.
- R10: Mode 5: a horizontal rising edge after a falling `vd_i` edge starts 0,1 lines. After a rising `vd_i` edge it starts 2,3 lines. With no vertical event, the line type stays as it is. Every line starts at its first entry.
- R11: Mode 6: lines are 0,1,0,1… or 1,2,1,2… and alternate on each horizontal rising edge. A pending vertical event forces 0,1. `idx_o` is never 3.
- R12: Mode 7: `idx_o` equals {`vd_i`,`hd_i`} as sampled at the most recent rising edge (00→gain0, 01→gain1, 10→gain2, 11→gain3).
- R13: A pending vertical event is set by a qualifying `vd_i` edge and cleared by the next horizontal rising edge. In modes 1, 3, 4 and 6 only a rising `vd_i` edge qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Horizontal sync |
| vd_i | input | 1 | Vertical sync |
| mode_i | input | 3 | Steering mode |
| enable_i | input | 1 | Gain selection enable |
| gain0_i | input | GAIN_W | Gain code slot 0 |
| gain1_i | input | GAIN_W | Gain code slot 1 |
| gain2_i | input | GAIN_W | Gain code slot 2 |
| gain3_i | input | GAIN_W | Gain code slot 3 |
| gain_o | output | GAIN_W | Selected gain code |
| idx_o | output | 2 | Selected slot index |

## Verification
The bench builds the block with the default 6-bit gain width. With that width the forced code is 63, and four distinct slot codes tell every index apart at the gain output. Each mode is entered from a different mode, so the restart to index 0 is seen every time. The line sequences place a falling vertical edge before a line so that modes 1, 2 and 5 must each give a different line type. The three- and four-colour tests start a line with no vertical event and check that the cycle runs on across it.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int NUM_GAIN = 4;
  localparam int IDX_W    = $clog2(NUM_GAIN);
  localparam int MODE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF       = 3'd0,
    MODE_ALT_LINE  = 3'd1,
    MODE_FIELD_ALT = 3'd2,
    MODE_TRI       = 3'd3,
    MODE_QUAD      = 3'd4,
    MODE_FIELD_SEL = 3'd5,
    MODE_SHIFT     = 3'd6,
    MODE_DIRECT    = 3'd7
  } steer_mode_e;
endpackage

// File: rtl/cs_sync_pair.sv
module cs_sync_pair #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      cur_o  <= d_i;
      prev_o <= cur_o;
    end
  end
endmodule

// File: rtl/cs_pattern_state.sv
module cs_pattern_state
  import cs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                hd_rise_i,
  input  logic                vd_rise_i,
  input  logic                vd_fall_i,
  output steer_mode_e         mode_o,
  output logic [IDX_W-1:0]    pix_o,
  output logic                line_o
);
  steer_mode_e       mode_q;
  logic [IDX_W-1:0]  pix_q, pix_d, pix_inc, pix_last;
  logic              line_q, line_d;
  logic              pend_q, pend_d;
  logic              pol_q, pol_d;
  logic              vd_qual, both_edges;

  always_comb begin
    both_edges = (mode_q == MODE_FIELD_ALT) || (mode_q == MODE_FIELD_SEL);
    vd_qual    = vd_rise_i | (vd_fall_i & both_edges);
    unique case (mode_q)
      MODE_TRI:  pix_last = IDX_W'(2);
      MODE_QUAD: pix_last = IDX_W'(NUM_GAIN - 1);
      default:   pix_last = IDX_W'(1);
    endcase
    pix_inc = (pix_q == pix_last) ? '0 : IDX_W'(pix_q + 1'b1);

    pix_d  = pix_inc;
    line_d = line_q;
    pend_d = pend_q;
    pol_d  = pol_q;

    if (hd_rise_i) begin
      pend_d = 1'b0;
      unique case (mode_q)
        MODE_ALT_LINE, MODE_FIELD_ALT, MODE_SHIFT: begin
          pix_d  = '0;
          line_d = pend_q ? 1'b0 : ~line_q;
        end
        MODE_FIELD_SEL: begin
          pix_d = '0;
          if (pend_q) line_d = pol_q;
        end
        MODE_TRI, MODE_QUAD: begin
          if (pend_q) pix_d = '0;
        end
        default: ;
      endcase
    end

    if (vd_qual) begin
      pend_d = 1'b1;
      pol_d  = vd_rise_i;
    end

    if (mode_i != mode_q) begin
      pix_d  = '0;
      line_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      pix_q  <= '0;
      line_q <= 1'b0;
      pend_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      mode_q <= steer_mode_e'(mode_i);
      pix_q  <= pix_d;
      line_q <= line_d;
      pend_q <= pend_d;
      pol_q  <= pol_d;
    end
  end

  assign mode_o = mode_q;
  assign pix_o  = pix_q;
  assign line_o = line_q;
endmodule

// File: rtl/cs_index_map.sv
module cs_index_map
  import cs_pkg::*;
(
  input  steer_mode_e       mode_i,
  input  logic [IDX_W-1:0]  pix_i,
  input  logic              line_i,
  input  logic              vd_lvl_i,
  input  logic              hd_lvl_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ALT_LINE, MODE_FIELD_ALT, MODE_FIELD_SEL: idx_o = {line_i, pix_i[0]};
      MODE_SHIFT:         idx_o = IDX_W'({1'b0, pix_i[0]} + {1'b0, line_i});
      MODE_TRI, MODE_QUAD: idx_o = pix_i;
      MODE_DIRECT:        idx_o = {vd_lvl_i, hd_lvl_i};
      default:            idx_o = '0;
    endcase
  end
endmodule

// File: rtl/cs_gain_mux.sv
module cs_gain_mux
  import cs_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic [NUM_GAIN-1:0][GAIN_W-1:0] gains_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            enable_i,
  output logic [GAIN_W-1:0]               gain_o
);
  logic [NUM_GAIN-1:0][GAIN_W-1:0] term;
  logic [GAIN_W-1:0]               picked;

  for (genvar g = 0; g < NUM_GAIN; g++) begin : g_term
    assign term[g] = (idx_i == IDX_W'(g)) ? gains_i[g] : '0;
  end

  always_comb begin
    picked = '0;
    for (int g = 0; g < NUM_GAIN; g++) picked = picked | term[g];
  end

  // disabled stage sits at the top code
  assign gain_o = enable_i ? picked : '1;
endmodule

// File: rtl/color_steer_sel.sv
module color_steer_sel
  import cs_pkg::*;
#(
  parameter int GAIN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic [2:0]        mode_i,
  input  logic              enable_i,
  input  logic [GAIN_W-1:0] gain0_i,
  input  logic [GAIN_W-1:0] gain1_i,
  input  logic [GAIN_W-1:0] gain2_i,
  input  logic [GAIN_W-1:0] gain3_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [1:0]        idx_o
);
  logic [1:0]        sync_cur, sync_prev;
  logic              hd_rise, vd_rise, vd_fall;
  steer_mode_e       mode_q;
  logic [IDX_W-1:0]  pix;
  logic              line_sel;
  logic [IDX_W-1:0]  idx;

  // bit 1 = vd, bit 0 = hd
  cs_sync_pair #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({vd_i, hd_i}),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  assign hd_rise = sync_cur[0] & ~sync_prev[0];
  assign vd_rise = sync_cur[1] & ~sync_prev[1];
  assign vd_fall = ~sync_cur[1] & sync_prev[1];

  cs_pattern_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .hd_rise_i (hd_rise),
    .vd_rise_i (vd_rise),
    .vd_fall_i (vd_fall),
    .mode_o    (mode_q),
    .pix_o     (pix),
    .line_o    (line_sel)
  );

  cs_index_map u_map (
    .mode_i   (mode_q),
    .pix_i    (pix),
    .line_i   (line_sel),
    .vd_lvl_i (sync_cur[1]),
    .hd_lvl_i (sync_cur[0]),
    .idx_o    (idx)
  );

  cs_gain_mux #(.GAIN_W(GAIN_W)) u_mux (
    .gains_i  ({gain3_i, gain2_i, gain1_i, gain0_i}),
    .idx_i    (idx),
    .enable_i (enable_i),
    .gain_o   (gain_o)
  );

  assign idx_o = idx;
endmodule

// File: rtl/cs_steer_chk.sv
module cs_steer_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hd_i,
  input logic              vd_i,
  input logic [2:0]        mode_i,
  input logic              enable_i,
  input logic [GAIN_W-1:0] gain0_i,
  input logic [GAIN_W-1:0] gain1_i,
  input logic [GAIN_W-1:0] gain2_i,
  input logic [GAIN_W-1:0] gain3_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic [1:0]        idx_o
);
  logic [1:0]        age;
  logic [GAIN_W-1:0] slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    unique case (idx_o)
      2'd0:    slot = gain0_i;
      2'd1:    slot = gain1_i;
      2'd2:    slot = gain2_i;
      default: slot = gain3_i;
    endcase
  end

  assert_mode_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && $past(mode_i) != $past(mode_i, 2) && $past(mode_i) != 3'd7)
      |-> idx_o == 2'd0);

  assert_forced_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> gain_o == {GAIN_W{1'b1}});

  assert_slot_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> gain_o == slot);

  assert_tri_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(mode_i) == 3'd3) |-> idx_o != 2'd3);

  assert_shift_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(mode_i) == 3'd6) |-> idx_o != 2'd3);

  assert_direct_index_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && $past(mode_i) == 3'd7) |-> idx_o == $past({vd_i, hd_i}));
endmodule

bind color_steer_sel cs_steer_chk #(.GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/sim_color_steer_sel.sv
`timescale 1ns/1ps
module sim_color_steer_sel;
  localparam int GW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hd = 1'b0, vd = 1'b0, en = 1'b1;
  logic [2:0]    mode = 3'd0;
  logic [GW-1:0] g [4];
  logic [GW-1:0] gain;
  logic [1:0]    idx;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  color_steer_sel #(.GAIN_W(GW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .vd_i(vd), .mode_i(mode),
    .enable_i(en), .gain0_i(g[0]), .gain1_i(g[1]), .gain2_i(g[2]),
    .gain3_i(g[3]), .gain_o(gain), .idx_o(idx)
  );

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode = m;
    step();
    if (m != 3'd7) chk("R1 restart index", idx, 0);
  endtask

  task automatic vd_to(input logic lvl);
    vd = lvl;
    repeat (6) step();
  endtask

  // new line, then check first three pixels
  task automatic hd_line(input string req, input int e0, input int e1);
    hd = 1'b1;
    step(); step();
    chk(req, idx, e0); step();
    chk(req, idx, e1); step();
    chk(req, idx, e0);
    repeat (3) step();
    hd = 1'b0;
    repeat (6) step();
  endtask

  task automatic t_reset();
    chk("R4 reset index", idx, 0);
    chk("R3 mode off gain0", gain, g[0]);
    step();
    chk("R3 mode off stays 0", idx, 0);
  endtask

  task automatic t_alt_line();
    set_mode(3'd1);
    step();
    chk("R6 second pixel", idx, 1);
    hd_line("R6 toggle to 2,3", 2, 3);
    vd_to(1'b1);
    hd_line("R6 vd rise gives 0,1", 0, 1);
    vd_to(1'b0);
    hd_line("R13 vd fall ignored", 2, 3);
  endtask

  task automatic t_field_alt();
    set_mode(3'd2);
    vd_to(1'b1);
    hd_line("R7 vd rise gives 0,1", 0, 1);
    vd_to(1'b0);
    hd_line("R7 vd fall gives 0,1", 0, 1);
    hd_line("R7 no vd toggles", 2, 3);
  endtask

  task automatic t_cycle(input logic [2:0] m, input int n, input string req);
    int prev;
    set_mode(m);
    for (int k = 1; k < n + 2; k++) begin
      step();
      chk(req, idx, k % n);
    end
    prev = idx;
    hd = 1'b1; step(); step();
    chk({req, " runs across line"}, idx, (prev + 2) % n);
    repeat (4) step();
    hd = 1'b0; repeat (6) step();
    vd_to(1'b1);
    hd = 1'b1; step(); step();
    chk({req, " restart after vd"}, idx, 0);
    step();
    chk({req, " restart next"}, idx, 1);
    repeat (4) step();
    hd = 1'b0; repeat (4) step();
    vd_to(1'b0);
  endtask

  task automatic t_field_sel();
    set_mode(3'd5);
    hd_line("R10 no vd keeps 0,1", 0, 1);
    vd_to(1'b1);
    hd_line("R10 vd rise gives 2,3", 2, 3);
    hd_line("R10 no vd keeps 2,3", 2, 3);
    vd_to(1'b0);
    hd_line("R10 vd fall gives 0,1", 0, 1);
  endtask

  task automatic t_shift();
    set_mode(3'd6);
    hd_line("R11 toggle to 1,2", 1, 2);
    hd_line("R11 toggle to 0,1", 0, 1);
    vd_to(1'b1);
    hd_line("R11 vd rise forces 0,1", 0, 1);
    vd_to(1'b0);
  endtask

  task automatic t_direct();
    set_mode(3'd7);
    vd = 1'b1; hd = 1'b0; step();
    chk("R12 vd only", idx, 2);
    vd = 1'b0; hd = 1'b1; step();
    chk("R12 hd only", idx, 1);
    vd = 1'b1; hd = 1'b1; step();
    chk("R12 both", idx, 3);
    vd = 1'b0; hd = 1'b0; step();
    chk("R12 none", idx, 0);
    repeat (6) step();
  endtask

  task automatic t_enable();
    set_mode(3'd4);
    chk("R3 slot 0", gain, g[0]);
    for (int k = 1; k < 4; k++) begin
      step();
      chk("R3 slot match", gain, g[k]);
    end
    step();
    en = 1'b0; #1;
    chk("R2 forced code", gain, 63);
    chk("R2 index runs", idx, 0);
    step();
    chk("R2 index advances", idx, 1);
    chk("R2 forced held", gain, 63);
    en = 1'b1; #1;
    chk("R3 re-enable", gain, g[1]);
    set_mode(3'd0);
    step();
    chk("R3 mode off index", idx, 0);
    chk("R3 mode off gain", gain, g[0]);
  endtask

  initial begin
    g[0] = 6'd10; g[1] = 6'd21; g[2] = 6'd42; g[3] = 6'd5;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_alt_line();
    t_field_alt();
    t_cycle(3'd3, 3, "R8 three-colour");
    t_cycle(3'd4, 4, "R9 four-colour");
    t_field_sel();
    t_shift();
    t_direct();
    t_enable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule